// File: doc/BRIEF.md
# Quadratic-Rate On-Time Ramp Generator

This block is a digital stand-in for the timing capacitor that sets the on-time of a boost power-factor stage. When a gate-start strobe arrives, an accumulator begins to rise from zero. On every clock it gains a step equal to twice the square of the feedback-current code divided by the reference-current code. Once the accumulated value goes strictly above the control-level code, the block raises a one-clock end-of-on-time pulse. The ramp then drops back to zero in a single clock and stays there until the next start.

The slope grows with the square of the feedback code, which tracks the output voltage. The longest on-time, reached when the control level is at its ceiling, therefore shrinks with the inverse square of the output voltage. This is what lets the regulated output follow the line amplitude. An external protection path, for example an overcurrent detector, can end the charge early with a gate-end strobe.

Top module: `quad_ontime_ramp`

## Requirements
- R1: While reset is high and on the first clock after it, the phase output reads idle (code 0), the ramp reads 0 and the end-of-on-time pulse is low.
- R2: A gate-start strobe seen in the idle phase moves the block to the charge phase (code 1) on the next clock, with the ramp still at 0.
- R3: In the charge phase, each clock without a gate-end strobe adds floor(2·fb²/ref) to the ramp, using the feedback and reference codes present on that clock.
- R4: The ramp saturates at the full-scale value 2^RAMP_W−1 and never wraps to a smaller value while charging.
- R5: When the updated ramp is strictly greater than the control level, the same edge sets the phase to discharge (code 2), loads that updated ramp value and raises the end-of-on-time output for exactly one clock. A ramp equal to the control level does not end the charge.
- R6: A gate-end strobe in the charge phase moves the block to discharge on the next clock. The ramp is left unadvanced and no end-of-on-time pulse is produced, even when the ramp would have crossed the control level on that clock.
- R7: The discharge phase lasts one clock. It is followed by the idle phase with the ramp at 0.
- R8: A gate-start strobe outside the idle phase and a gate-end strobe outside the charge phase have no effect on the phase, the ramp or the pulse.
- R9: A reference code of zero, or a quotient above full scale, gives a step of full scale.
- R10: In the idle phase the ramp is held at 0 for as long as no gate-start strobe arrives.

Port widths use FB_W = 10, REF_W = 10, RAMP_W = 16 (defaults).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_start | input | 1 | Turn-on strobe; begins a charge from idle |
| gate_end | input | 1 | Forced turn-off strobe; ends a charge early |
| fb_code | input | FB_W | Feedback-current code |
| ref_code | input | REF_W | Reference-current code |
| ctrl_level | input | RAMP_W | Control level the ramp is compared against |
| ramp_value | output | RAMP_W | Present ramp value |
| ontime_end | output | 1 | One-clock pulse when the ramp passes the control level |
| ramp_phase | output | 2 | 0 idle, 1 charge, 2 discharge |

## Verification
The bench builds the block with its default widths: a 10-bit feedback code, a 10-bit reference code and a 16-bit ramp. With these widths, a feedback and reference code of 200 reproduce the nominal 400-per-clock slope, and a feedback code of 100 gives 100 per clock. A maximal feedback code over a reference of one drives the quotient far past the 16-bit range, which exercises saturation of both the step and the accumulator. A control level of full scale is also reachable; because the comparison is strict, the ramp sits pinned at its ceiling until a gate-end strobe arrives.

// File: rtl/onramp_pkg.sv
package onramp_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_CHARGE = 2'd1,
        PH_DISCH  = 2'd2
    } ramp_phase_e;

    typedef enum logic [1:0] {
        ACC_HOLD    = 2'd0,
        ACC_CLEAR   = 2'd1,
        ACC_ADVANCE = 2'd2
    } acc_cmd_e;

    typedef struct packed {
        ramp_phase_e phase;
        logic        pulse;
    } seq_state_t;

endpackage

// File: rtl/onramp_slope.sv
module onramp_slope #(
    parameter int FB_W   = 10,
    parameter int REF_W  = 10,
    parameter int RAMP_W = 16
) (
    input  logic [FB_W-1:0]   fb_code,
    input  logic [REF_W-1:0]  ref_code,
    output logic [RAMP_W-1:0] step
);
    localparam int PROD_W = 2 * FB_W + 1;
    localparam int DIV_W  = (PROD_W > REF_W) ? PROD_W : REF_W;
    localparam logic [RAMP_W-1:0] FULL = {RAMP_W{1'b1}};

    logic [DIV_W-1:0] fb_ext;
    logic [DIV_W-1:0] twice_sq;
    logic [DIV_W-1:0] divisor;
    logic [DIV_W-1:0] quotient;
    logic             ref_zero;
    logic             too_big;

    assign fb_ext   = DIV_W'(fb_code);
    assign twice_sq = (fb_ext * fb_ext) << 1;
    assign ref_zero = (ref_code == '0);
    assign divisor  = ref_zero ? DIV_W'(1) : DIV_W'(ref_code);
    assign quotient = twice_sq / divisor;

    generate
        if (DIV_W > RAMP_W) begin : g_range_check
            assign too_big = (quotient[DIV_W-1:RAMP_W] != '0);
        end else begin : g_no_range_check
            assign too_big = 1'b0;
        end
    endgenerate

    assign step = (ref_zero || too_big) ? FULL : quotient[RAMP_W-1:0];

endmodule

// File: rtl/onramp_accum.sv
module onramp_accum
    import onramp_pkg::*;
#(
    parameter int RAMP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_cmd_e          cmd,
    input  logic [RAMP_W-1:0] step,
    output logic [RAMP_W-1:0] ramp_q,
    output logic [RAMP_W-1:0] sum_next
);
    localparam logic [RAMP_W-1:0] FULL = {RAMP_W{1'b1}};

    logic [RAMP_W:0] raw_sum;

    assign raw_sum  = {1'b0, ramp_q} + {1'b0, step};
    assign sum_next = raw_sum[RAMP_W] ? FULL : raw_sum[RAMP_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ramp_q <= '0;
        end else begin
            case (cmd)
                ACC_CLEAR:   ramp_q <= '0;
                ACC_ADVANCE: ramp_q <= sum_next;
                default:     ramp_q <= ramp_q;
            endcase
        end
    end

    a_r4_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (cmd == ACC_ADVANCE) |=> (ramp_q >= $past(ramp_q)));

endmodule

// File: rtl/onramp_seq.sv
module onramp_seq
    import onramp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        stop_i,
    input  logic        exceed_i,
    output ramp_phase_e phase_o,
    output logic        pulse_o,
    output acc_cmd_e    cmd_o
);
    seq_state_t cur_s, nxt_s;

    always_comb begin
        nxt_s       = cur_s;
        nxt_s.pulse = 1'b0;
        cmd_o       = ACC_HOLD;
        case (cur_s.phase)
            PH_IDLE: begin
                cmd_o = ACC_CLEAR;
                if (start_i) nxt_s.phase = PH_CHARGE;
            end
            PH_CHARGE: begin
                if (stop_i) begin
                    nxt_s.phase = PH_DISCH;
                end else begin
                    cmd_o = ACC_ADVANCE;
                    if (exceed_i) begin
                        nxt_s.phase = PH_DISCH;
                        nxt_s.pulse = 1'b1;
                    end
                end
            end
            PH_DISCH: begin
                cmd_o       = ACC_CLEAR;
                nxt_s.phase = PH_IDLE;
            end
            default: begin
                cmd_o       = ACC_CLEAR;
                nxt_s.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_s.phase <= PH_IDLE;
            cur_s.pulse <= 1'b0;
        end else begin
            cur_s <= nxt_s;
        end
    end

    assign phase_o = cur_s.phase;
    assign pulse_o = cur_s.pulse;

    a_r7_disch_single: assert property (@(posedge clk) disable iff (rst)
        (cur_s.phase == PH_DISCH) |=> (cur_s.phase == PH_IDLE));

    a_r5_pulse_single: assert property (@(posedge clk) disable iff (rst)
        cur_s.pulse |=> !cur_s.pulse);

endmodule

// File: rtl/quad_ontime_ramp.sv
module quad_ontime_ramp
    import onramp_pkg::*;
#(
    parameter int FB_W   = 10,
    parameter int REF_W  = 10,
    parameter int RAMP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gate_start,
    input  logic              gate_end,
    input  logic [FB_W-1:0]   fb_code,
    input  logic [REF_W-1:0]  ref_code,
    input  logic [RAMP_W-1:0] ctrl_level,
    output logic [RAMP_W-1:0] ramp_value,
    output logic              ontime_end,
    output logic [1:0]        ramp_phase
);
    logic [RAMP_W-1:0] step;
    logic [RAMP_W-1:0] sum_next;
    logic              exceed;
    acc_cmd_e          cmd;
    ramp_phase_e       phase;

    onramp_slope #(.FB_W(FB_W), .REF_W(REF_W), .RAMP_W(RAMP_W)) u_slope (
        .fb_code  (fb_code),
        .ref_code (ref_code),
        .step     (step)
    );

    onramp_accum #(.RAMP_W(RAMP_W)) u_accum (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .step     (step),
        .ramp_q   (ramp_value),
        .sum_next (sum_next)
    );

    assign exceed = (sum_next > ctrl_level);

    onramp_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (gate_start),
        .stop_i   (gate_end),
        .exceed_i (exceed),
        .phase_o  (phase),
        .pulse_o  (ontime_end),
        .cmd_o    (cmd)
    );

    assign ramp_phase = phase;

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (ramp_phase == 2'd0) |-> (ramp_value == '0));

    a_r2_start_charge: assert property (@(posedge clk) disable iff (rst)
        (ramp_phase == 2'd0 && gate_start) |=> (ramp_phase == 2'd1 && ramp_value == '0));

    a_r5_pulse_above: assert property (@(posedge clk) disable iff (rst)
        ontime_end |-> (ramp_phase == 2'd2 && ramp_value > $past(ctrl_level)));

    a_r6_forced_end: assert property (@(posedge clk) disable iff (rst)
        (ramp_phase == 2'd1 && gate_end) |=>
            (ramp_phase == 2'd2 && !ontime_end && $stable(ramp_value)));

    a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (ramp_phase == 2'd2 && gate_start) |=> (ramp_phase == 2'd0));

endmodule

// File: tb/tb_quad_ontime_ramp.sv
module tb_quad_ontime_ramp;
    localparam int FB_W   = 10;
    localparam int REF_W  = 10;
    localparam int RAMP_W = 16;
    localparam longint FULL = (64'd1 << RAMP_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              gate_start = 1'b0;
    logic              gate_end = 1'b0;
    logic [FB_W-1:0]   fb_code = '0;
    logic [REF_W-1:0]  ref_code = '0;
    logic [RAMP_W-1:0] ctrl_level = '0;
    logic [RAMP_W-1:0] ramp_value;
    logic              ontime_end;
    logic [1:0]        ramp_phase;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    int     m_phase = 0;
    longint m_ramp  = 0;
    bit     m_eot   = 1'b0;

    always #5 clk = ~clk;

    quad_ontime_ramp #(.FB_W(FB_W), .REF_W(REF_W), .RAMP_W(RAMP_W)) dut (
        .clk        (clk),
        .rst        (rst),
        .gate_start (gate_start),
        .gate_end   (gate_end),
        .fb_code    (fb_code),
        .ref_code   (ref_code),
        .ctrl_level (ctrl_level),
        .ramp_value (ramp_value),
        .ontime_end (ontime_end),
        .ramp_phase (ramp_phase)
    );

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected < 5000", cycles);
            finish_run();
        end
    end

    task automatic compare(string tag);
        checks++;
        if (int'(ramp_phase) != m_phase || longint'(ramp_value) != m_ramp || ontime_end != m_eot) begin
            fails++;
            $display("FAIL %s: actual phase=%0d ramp=%0d eot=%0d expected phase=%0d ramp=%0d eot=%0d",
                     tag, ramp_phase, ramp_value, ontime_end, m_phase, m_ramp, m_eot);
        end
    endtask

    // one clock: drive inputs at negedge, advance model, compare at next negedge
    task automatic step(bit s, bit e, int f, int r, int c, string tag);
        longint inc;
        longint nr;
        gate_start = s;
        gate_end   = e;
        fb_code    = FB_W'(f);
        ref_code   = REF_W'(r);
        ctrl_level = RAMP_W'(c);
        if (r == 0) inc = FULL;
        else begin
            inc = (2 * longint'(f) * longint'(f)) / longint'(r);
            if (inc > FULL) inc = FULL;
        end
        @(posedge clk);
        m_eot = 1'b0;
        case (m_phase)
            0: if (s) m_phase = 1;
            1: begin
                if (e) m_phase = 2;
                else begin
                    nr = m_ramp + inc;
                    if (nr > FULL) nr = FULL;
                    m_ramp = nr;
                    if (nr > longint'(c)) begin
                        m_phase = 2;
                        m_eot   = 1'b1;
                    end
                end
            end
            default: begin
                m_phase = 0;
                m_ramp  = 0;
            end
        endcase
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        compare("R1");                       // during reset
        rst = 1'b0;
        step(0, 0, 0, 200, 0, "R1");          // first clock after reset
        // R10 idle hold, R8 stray gate_end in idle
        step(0, 0, 200, 200, 1500, "R10");
        step(0, 1, 200, 200, 1500, "R8");
        // nominal: 2*200^2/200 = 400 per clock, cross at 1600 > 1500
        step(1, 0, 200, 200, 1500, "R2");
        step(0, 0, 200, 200, 1500, "R3");
        step(0, 0, 200, 200, 1500, "R3");
        step(0, 0, 200, 200, 1500, "R3");
        step(1, 0, 200, 200, 1500, "R5");     // stray start in discharge? crosses here
        step(1, 0, 200, 200, 1500, "R7");
        step(0, 0, 200, 200, 1500, "R10");
        // 2*100^2/200 = 100 per clock; equal to level does not end (R5)
        step(1, 0, 100, 200, 300, "R2");
        step(0, 0, 100, 200, 300, "R3");
        step(1, 0, 100, 200, 300, "R8");      // start ignored in charge
        step(0, 0, 100, 200, 300, "R5");      // ramp 300 == level, still charging
        step(0, 0, 100, 200, 300, "R5");      // 400 > 300
        step(0, 1, 100, 200, 300, "R7");      // gate_end in discharge ignored
        // odd ratio: 2*9/7 = 2
        step(1, 0, 3, 7, 1000, "R2");
        step(0, 0, 3, 7, 1000, "R3");
        step(0, 0, 3, 7, 1000, "R3");
        // varying feedback mid-charge
        step(0, 0, 50, 100, 1000, "R3");
        step(0, 0, 150, 100, 1000, "R3");
        // forced end mid-charge
        step(0, 1, 150, 100, 1000, "R6");
        step(0, 0, 150, 100, 1000, "R7");
        // forced end when the ramp would have crossed: no pulse
        step(1, 0, 200, 200, 500, "R2");
        step(0, 0, 200, 200, 500, "R3");
        step(0, 1, 200, 200, 500, "R6");
        step(0, 0, 200, 200, 500, "R7");
        // saturation: huge quotient, full-scale level never exceeded
        step(1, 0, 1023, 1, 65535, "R2");
        step(0, 0, 1023, 1, 65535, "R9");
        step(0, 0, 1023, 1, 65535, "R4");
        step(0, 0, 200, 200, 65535, "R4");
        step(0, 1, 200, 200, 65535, "R6");
        step(0, 0, 200, 200, 65535, "R7");
        // zero reference gives full-scale step
        step(1, 0, 5, 0, 100, "R2");
        step(0, 0, 5, 0, 100, "R9");
        step(0, 0, 5, 0, 100, "R7");
        step(0, 0, 5, 0, 100, "R10");
        // reset in mid-charge
        step(1, 0, 200, 200, 60000, "R2");
        step(0, 0, 200, 200, 60000, "R3");
        rst = 1'b1;
        @(posedge clk);
        m_phase = 0;
        m_ramp  = 0;
        m_eot   = 1'b0;
        @(negedge clk);
        compare("R1");
        rst = 1'b0;
        step(0, 0, 200, 200, 60000, "R10");
        finish_run();
    end

endmodule